// File: doc/BRIEF.md
# Bitwise Logic Unit with Condition Recording

This block is the logical-operation slice of a RISC integer execute stage. It combines a 32-bit register source with either a second register source or a 16-bit immediate, and applies one of eight bitwise functions. The 32-bit result goes to the destination register. An issue strobe qualifies each operation, and the result is presented from a register one cycle later.

An immediate is widened in one of two ways before use: it is zero-extended, or it is placed in the upper halfword with zeros below. On request, the unit also produces a 4-bit condition field that summarises the result. With register operands the request is honoured as given. With immediate operands, the AND function always records and every other function never does. The summary-overflow input is only read and copied into the condition field. The unit has no path that writes the fixed-point exception register.

Top module: `bitlogic_unit`

## Requirements
- R1: `op_sel` picks the function: 0 AND, 1 NAND, 2 OR, 3 NOR, 4 XOR, 5 EQV (complement of XOR), 6 ANDC (`src_a & ~b`), 7 ORC (`src_a | ~b`). All functions work bit by bit over 32 bits.
- R2: The NAND result is the bitwise complement of the AND result for the same operands.
- R3: With `use_imm`=1 and `imm_hi`=0, the second operand is `{16'h0, imm}`.
- R4: With `use_imm`=1 and `imm_hi`=1, the second operand is `{imm, 16'h0}`.
- R5: With `use_imm`=0, the second operand is `src_b` and `imm` has no effect on the result.
- R6: `out_valid` rises exactly one cycle after a cycle with `in_valid`=1 and is 0 otherwise. `result` and `cr_field` of that operation are presented in the same cycle as `out_valid`.
- R7: When an operation records, `cr_wr` is 1 and `cr_field[3]`=LT, `cr_field[2]`=GT and `cr_field[1]`=EQ come from a signed comparison of the result with zero. Exactly one of these three bits is set.
- R8: When an operation records, `cr_field[0]` equals the `so_in` value that was sampled with the operation.
- R9: A register-operand operation with `rec_en`=0 gives `cr_wr`=0 and `cr_field`=0.
- R10: An immediate operation other than AND never records, even when `rec_en`=1.
- R11: An immediate AND always records, even when `rec_en`=0.
- R12: `so_in` has no effect on `result`.
- R13: While reset is asserted and after it is released, `out_valid`, `cr_wr`, `cr_field` and `result` are 0 until the first operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issued this cycle |
| op_sel | input | 3 | Function select (see R1) |
| src_a | input | 32 | Register source operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate operand |
| use_imm | input | 1 | Use the immediate instead of src_b |
| imm_hi | input | 1 | Place the immediate in the upper halfword |
| rec_en | input | 1 | Record request for register forms |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Destination value |
| cr_wr | output | 1 | Condition field write enable |
| cr_field | output | 4 | LT, GT, EQ, SO (bits 3..0) |

## Verification
The result and its condition field are both produced in the one cycle after issue. An error in either one, or in how they line up, therefore appears at the same sample point. The bench provokes this with operands whose results are negative, positive and zero, and with `so_in` toggled. It judges `result`, `cr_wr` and every bit of `cr_field` together against a model computed from the requirements. The immediate forms carry the sharpest case. There an immediate AND with `rec_en`=0 must still record, and an immediate OR with `rec_en`=1 must not, both in the same cycle as a correctly widened immediate.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;
   localparam int OP_W = 3;
   localparam int CR_W = 4;

   typedef enum logic [OP_W-1:0] {
      LOP_AND  = 3'd0,
      LOP_NAND = 3'd1,
      LOP_OR   = 3'd2,
      LOP_NOR  = 3'd3,
      LOP_XOR  = 3'd4,
      LOP_EQV  = 3'd5,
      LOP_ANDC = 3'd6,
      LOP_ORC  = 3'd7
   } lop_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } crf_t;
endpackage

// File: rtl/bitlogic_opnd.sv
module bitlogic_opnd #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [DATA_W-1:0] reg_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_imm,
   input  logic              imm_hi,
   output logic [DATA_W-1:0] opnd_b
);
   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_lo_ext;
   logic [DATA_W-1:0] imm_hi_ext;

   generate
      if (IMM_W > DATA_W) begin : g_bad
         $error("bitlogic_opnd: IMM_W must not exceed DATA_W");
      end else if (PAD_W == 0) begin : g_same
         assign imm_lo_ext = imm;
         assign imm_hi_ext = imm;
      end else begin : g_pad
         assign imm_lo_ext = {{PAD_W{1'b0}}, imm};
         assign imm_hi_ext = {imm, {PAD_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      if (!use_imm)    opnd_b = reg_b;
      else if (imm_hi) opnd_b = imm_hi_ext;
      else             opnd_b = imm_lo_ext;
   end
endmodule

// File: rtl/bitlogic_core.sv
module bitlogic_core
   import bitlogic_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [OP_W-1:0]   op_sel,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   lop_e op;
   assign op = lop_e'(op_sel);

   always_comb begin
      unique case (op)
         LOP_AND:  y = a & b;
         LOP_NAND: y = ~(a & b);
         LOP_OR:   y = a | b;
         LOP_NOR:  y = ~(a | b);
         LOP_XOR:  y = a ^ b;
         LOP_EQV:  y = ~(a ^ b);
         LOP_ANDC: y = a & ~b;
         LOP_ORC:  y = a | ~b;
         default:  y = '0;
      endcase
   end
endmodule

// File: rtl/bitlogic_flags.sv
module bitlogic_flags
   import bitlogic_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] y,
   input  logic              so_in,
   output crf_t              crf
);
   logic is_zero;
   assign is_zero = (y == '0);

   always_comb begin
      crf.lt = y[DATA_W-1];
      crf.eq = is_zero;
      crf.gt = !y[DATA_W-1] && !is_zero;
      crf.so = so_in;
   end
endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
   import bitlogic_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [IMM_W-1:0]  imm,
   input  logic              use_imm,
   input  logic              imm_hi,
   input  logic              rec_en,
   input  logic              so_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              cr_wr,
   output logic [3:0]        cr_field
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("bitlogic_unit: DATA_W too small");
      end
   endgenerate

   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] y_comb;
   crf_t              crf_comb;
   logic              rec_eff;

   bitlogic_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) opnd_i (
      .reg_b(src_b), .imm(imm), .use_imm(use_imm), .imm_hi(imm_hi),
      .opnd_b(opnd_b)
   );

   bitlogic_core #(.DATA_W(DATA_W)) core_i (
      .op_sel(op_sel), .a(src_a), .b(opnd_b), .y(y_comb)
   );

   bitlogic_flags #(.DATA_W(DATA_W)) flags_i (
      .y(y_comb), .so_in(so_in), .crf(crf_comb)
   );

   // Immediate forms: only AND records, and it always does.
   assign rec_eff = use_imm ? (op_sel == LOP_AND) : rec_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         cr_wr     <= 1'b0;
         cr_field  <= '0;
      end else begin
         out_valid <= in_valid;
         cr_wr     <= in_valid && rec_eff;
         cr_field  <= (in_valid && rec_eff) ? crf_comb : '0;
         if (in_valid) result <= y_comb;
      end
   end

   assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_cr_one_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cr_wr |-> ($countones(cr_field[3:1]) == 1 && out_valid));
   assert_cr_eq_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cr_wr |-> (cr_field[1] == (result == '0)));
   assert_cr_so_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && rec_eff |=> cr_field[0] == $past(so_in));
   assert_quiet_cr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cr_wr |-> cr_field == '0);
   assert_imm_norec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && use_imm && op_sel != LOP_AND |=> !cr_wr);
   assert_imm_and_rec_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && use_imm && op_sel == LOP_AND |=> cr_wr);
endmodule

// File: tb/bitlogic_unit_tb_top.sv
module bitlogic_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [15:0] imm = '0;
   logic        use_imm = 1'b0;
   logic        imm_hi = 1'b0;
   logic        rec_en = 1'b0;
   logic        so_in = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        cr_wr;
   logic [3:0]  cr_field;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bitlogic_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .src_a(src_a), .src_b(src_b), .imm(imm), .use_imm(use_imm),
      .imm_hi(imm_hi), .rec_en(rec_en), .so_in(so_in),
      .out_valid(out_valid), .result(result), .cr_wr(cr_wr), .cr_field(cr_field)
   );

   function automatic logic [31:0] ref_op(input logic [2:0] op, input logic [31:0] a,
                                           input logic [31:0] b);
      case (op)
         3'd0: return a & b;
         3'd1: return ~(a & b);
         3'd2: return a | b;
         3'd3: return ~(a | b);
         3'd4: return a ^ b;
         3'd5: return ~(a ^ b);
         3'd6: return a & ~b;
         default: return a | ~b;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Issue one operation, then sample after the registering edge.
   task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic ui, input logic hi,
                        input logic rec, input logic so);
      @(negedge clk);
      in_valid = 1'b1; op_sel = op; src_a = a; src_b = b; imm = im;
      use_imm = ui; imm_hi = hi; rec_en = rec; so_in = so;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_check(input string req, input logic [2:0] op, input logic [31:0] a,
                            input logic [31:0] b, input logic [15:0] im, input logic ui,
                            input logic hi, input logic rec, input logic so);
      logic [31:0] bb, y;
      logic        re;
      logic [3:0]  cf;
      bb = !ui ? b : (hi ? {im, 16'h0} : {16'h0, im});
      y  = ref_op(op, a, bb);
      re = ui ? (op == 3'd0) : rec;
      cf = re ? {y[31], !y[31] && y != 0, y == 0, so} : 4'h0;
      issue(op, a, b, im, ui, hi, rec, so);
      chk({req, " valid"}, {31'h0, out_valid}, 32'h1);
      chk({req, " result"}, result, y);
      chk({req, " cr_wr"}, {31'h0, cr_wr}, {31'h0, re});
      chk({req, " cr_field"}, {28'h0, cr_field}, {28'h0, cf});
   endtask

   task automatic t_reset;
      chk("R13 reset valid", {31'h0, out_valid}, 32'h0);
      chk("R13 reset result", result, 32'h0);
      chk("R13 reset cr", {27'h0, cr_wr, cr_field}, 32'h0);
   endtask

   task automatic t_all_ops;
      for (int k = 0; k < 8; k++) begin
         run_check("R1", 3'(k), 32'hF0F0_1234, 32'hFF00_5678, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
         run_check("R1", 3'(k), 32'h0000_FFFF, 32'hA5A5_A5A5, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
      end
   endtask

   task automatic t_nand;
      logic [31:0] r_and;
      issue(3'd0, 32'h1357_9BDF, 32'hFFFF_0000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      r_and = result;
      issue(3'd1, 32'h1357_9BDF, 32'hFFFF_0000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R2 nand complement", result, ~r_and);
   endtask

   task automatic t_imm;
      run_check("R3 zext", 3'd2, 32'h8000_0000, 32'h0, 16'hBEEF, 1'b1, 1'b0, 1'b1, 1'b0);
      run_check("R4 shift", 3'd4, 32'h1234_5678, 32'h0, 16'hBEEF, 1'b1, 1'b1, 1'b0, 1'b0);
      run_check("R5 reg ignores imm", 3'd2, 32'h0, 32'h0000_0011, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_latency;
      issue(3'd2, 32'h1, 32'h2, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6 valid one cycle", {31'h0, out_valid}, 32'h1);
      @(negedge clk);
      chk("R6 valid drops", {31'h0, out_valid}, 32'h0);
      chk("R6 result held", result, 32'h3);
   endtask

   task automatic t_record;
      run_check("R7 negative", 3'd2, 32'h8000_0001, 32'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
      run_check("R7 positive", 3'd2, 32'h0000_0001, 32'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
      run_check("R7 zero", 3'd0, 32'hFFFF_0000, 32'h0000_FFFF, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
      run_check("R8 so copy", 3'd3, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);
      run_check("R9 no record", 3'd4, 32'h0, 32'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
      run_check("R10 imm or", 3'd2, 32'h0, 32'h0, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1);
      run_check("R10 imm xor hi", 3'd4, 32'hFFFF_FFFF, 32'h0, 16'h1, 1'b1, 1'b1, 1'b1, 1'b0);
      run_check("R11 imm and", 3'd0, 32'hFFFF_FFFF, 32'h0, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b1);
      run_check("R11 imm and zero", 3'd0, 32'hFFFF_0000, 32'h0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_so_result;
      logic [31:0] r0;
      issue(3'd5, 32'h0F0F_0F0F, 32'h3333_3333, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
      r0 = result;
      issue(3'd5, 32'h0F0F_0F0F, 32'h3333_3333, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);
      chk("R12 so no effect", result, r0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_all_ops();
      t_nand();
      t_imm();
      t_latency();
      t_record();
      t_so_result();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule